// File: doc/BRIEF.md
# Exception Return Status Shifter

This block applies the status-word update that a processor performs when it returns from an exception handler or from a non-maskable interrupt handler. At entry, the exception logic pushes the status fields upward inside the status word. On the return, this block pops them back down with a partial right shift that keeps the two most significant status bits where they are. It then applies two flag rules. The first rule, the pending-return flag P, depends on the R flag that was present before the pop. The second rule applies only to the NMI return, which always sets the M flag. If the popped status selects user mode, the block also exchanges stacks: the live stack pointer is stored as the saved kernel stack pointer, and the live stack pointer is loaded from the user stack pointer.

The pipeline raises one of two return strobes for a single cycle and supplies the current status word, stack pointer and user stack pointer. One clock later the block presents the new status word, the new stack pointer and the kernel stack pointer, and pulses `done`. A small controller with three states tracks the return in flight. `ST_IDLE` means no return has been applied. `ST_EXC_DONE` means an exception return was applied on the previous edge, and `ST_NMI_DONE` means an NMI return was applied on the previous edge. The transitions are as follows. From any state, a strobe on `rfe_go` moves to `ST_EXC_DONE` and a strobe on `rfn_go` moves to `ST_NMI_DONE`. A cycle with no strobe moves to `ST_IDLE`. Reset also forces `ST_IDLE`. The two strobes never arrive together.

Top module: `xret_status_unit`

## Requirements
- R1: While `rst_n` is low, `stat_out`, `sp_out` and `ksp_out` are all zero and `done` is low.
- R2: One clock after either strobe, bits 31:30 of `stat_out` are taken unchanged from `stat_in` bits 31:30. Bits 17:0 are `stat_in` bits 27:10, bits 29:18 are zero, and `stat_in` bits 29:28 and 9:0 are discarded. Bits 7 and 9 may then be modified by R3 and R4.
- R3: When the R flag (bit 8 of `stat_in`) is 0 on the strobe cycle, the P flag (bit 7 of `stat_out`) is 1 after the update. When the R flag is 1, bit 7 keeps the value moved into it by the shift (`stat_in` bit 17).
- R4: After an NMI return (`rfn_go`), the M flag (bit 9 of `stat_out`) is always 1. After an exception return (`rfe_go`), bit 9 keeps the shifted value (`stat_in` bit 19).
- R5: When the U flag of the shifted word is 1 (bit 6 after the shift, that is `stat_in` bit 16), `ksp_out` takes the `sp_in` value and `sp_out` takes the `usp_in` value.
- R6: When the shifted U flag is 0, `sp_out` takes `sp_in` and `ksp_out` keeps its previous value.
- R7: `done` is high during exactly the cycle that follows each strobe cycle, and low after a cycle without a strobe.
- R8: In a cycle without a strobe, `stat_out`, `sp_out` and `ksp_out` hold their values whatever `stat_in`, `sp_in` and `usp_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfe_go | input | 1 | Exception-return strobe, one cycle |
| rfn_go | input | 1 | NMI-return strobe, one cycle |
| stat_in | input | DATA_W | Status word before the return |
| sp_in | input | DATA_W | Current stack pointer |
| usp_in | input | DATA_W | User stack pointer |
| stat_out | output | DATA_W | Status word after the return |
| sp_out | output | DATA_W | Stack pointer after the return |
| ksp_out | output | DATA_W | Saved kernel stack pointer |
| done | output | 1 | High the cycle after a return was applied |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, two kept top bits, a 28-bit poppable field, a 10-bit pop, and flag positions U=6, P=7, R=8, M=9. These values put every shift boundary in reach. The discarded bits 29:28 are exercised, as is a fully set poppable field that lands in bits 17:0. The vectors also include a P bit that arrives by the shift while R is set, and an M bit that arrives by the shift on an exception return. Stack swaps alternate with non-swapping returns so that the held kernel stack pointer is observed between swaps, and idle cycles with changed inputs show that the outputs hold.

// File: rtl/xret_pkg.sv
package xret_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXC_DONE = 2'd1,
        ST_NMI_DONE = 2'd2
    } xret_state_e;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_EXC  = 2'd1,
        RET_NMI  = 2'd2
    } ret_kind_e;

endpackage

// File: rtl/xret_pop_shift.sv
module xret_pop_shift
    import xret_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int KEEP_HI   = 2,
    parameter int LOW_W     = 28,
    parameter int POP_SHIFT = 10,
    parameter int P_BIT     = 7,
    parameter int R_BIT     = 8,
    parameter int M_BIT     = 9
) (
    input  logic [DATA_W-1:0] stat_old,
    input  ret_kind_e         kind,
    output logic [DATA_W-1:0] stat_new
);

    localparam int KEEP_LO = DATA_W - KEEP_HI;

    logic [DATA_W-1:0] shifted;

    // Each result bit is either a kept top bit, a popped bit or zero.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i >= KEEP_LO) begin : g_keep
            assign shifted[i] = stat_old[i];
        end else if (i + POP_SHIFT < LOW_W) begin : g_pop
            assign shifted[i] = stat_old[i + POP_SHIFT];
        end else begin : g_zero
            assign shifted[i] = 1'b0;
        end
    end

    // Bits between the poppable field and the kept top are dropped.
    if (LOW_W < KEEP_LO) begin : g_drop
        logic unused_dropped;
        assign unused_dropped = ^stat_old[KEEP_LO-1:LOW_W];
    end

    always_comb begin
        stat_new = shifted;
        if (!stat_old[R_BIT]) begin
            stat_new[P_BIT] = 1'b1;
        end
        if (kind == RET_NMI) begin
            stat_new[M_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/xret_sp_select.sv
module xret_sp_select #(
    parameter int DATA_W = 32
) (
    input  logic              user_sel,
    input  logic [DATA_W-1:0] sp_cur,
    input  logic [DATA_W-1:0] usp_cur,
    input  logic [DATA_W-1:0] ksp_cur,
    output logic [DATA_W-1:0] sp_next,
    output logic [DATA_W-1:0] ksp_next
);

    always_comb begin
        if (user_sel) begin
            sp_next  = usp_cur;
            ksp_next = sp_cur;
        end else begin
            sp_next  = sp_cur;
            ksp_next = ksp_cur;
        end
    end

endmodule

// File: rtl/xret_status_unit.sv
module xret_status_unit
    import xret_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int KEEP_HI   = 2,
    parameter int LOW_W     = 28,
    parameter int POP_SHIFT = 10,
    parameter int U_BIT     = 6,
    parameter int P_BIT     = 7,
    parameter int R_BIT     = 8,
    parameter int M_BIT     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfe_go,
    input  logic              rfn_go,
    input  logic [DATA_W-1:0] stat_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] usp_in,
    output logic [DATA_W-1:0] stat_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] ksp_out,
    output logic              done
);

    xret_state_e       state_q, state_d;
    ret_kind_e         kind;
    logic              any_go;
    logic [DATA_W-1:0] stat_nx;
    logic [DATA_W-1:0] sp_nx;
    logic [DATA_W-1:0] ksp_nx;

    always_comb begin
        if (rfn_go) begin
            kind = RET_NMI;
        end else if (rfe_go) begin
            kind = RET_EXC;
        end else begin
            kind = RET_NONE;
        end
    end

    assign any_go = (kind != RET_NONE);

    xret_pop_shift #(
        .DATA_W    (DATA_W),
        .KEEP_HI   (KEEP_HI),
        .LOW_W     (LOW_W),
        .POP_SHIFT (POP_SHIFT),
        .P_BIT     (P_BIT),
        .R_BIT     (R_BIT),
        .M_BIT     (M_BIT)
    ) u_pop (
        .stat_old (stat_in),
        .kind     (kind),
        .stat_new (stat_nx)
    );

    xret_sp_select #(
        .DATA_W (DATA_W)
    ) u_sp (
        .user_sel (stat_nx[U_BIT]),
        .sp_cur   (sp_in),
        .usp_cur  (usp_in),
        .ksp_cur  (ksp_out),
        .sp_next  (sp_nx),
        .ksp_next (ksp_nx)
    );

    // Next-state selection
    always_comb begin
        unique case (kind)
            RET_EXC:  state_d = ST_EXC_DONE;
            RET_NMI:  state_d = ST_NMI_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_EXC_DONE: done = 1'b1;
            ST_NMI_DONE: done = 1'b1;
            default:     done = 1'b0;
        endcase
    end

    // Architectural registers, written only on a return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_out <= '0;
            sp_out   <= '0;
            ksp_out  <= '0;
        end else if (any_go) begin
            stat_out <= stat_nx;
            sp_out   <= sp_nx;
            ksp_out  <= ksp_nx;
        end
    end

endmodule

// File: rtl/xret_status_sva.sv
module xret_status_sva #(
    parameter int DATA_W    = 32,
    parameter int KEEP_HI   = 2,
    parameter int POP_SHIFT = 10,
    parameter int U_BIT     = 6,
    parameter int P_BIT     = 7,
    parameter int R_BIT     = 8,
    parameter int M_BIT     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rfe_go,
    input logic              rfn_go,
    input logic [DATA_W-1:0] stat_in,
    input logic [DATA_W-1:0] sp_in,
    input logic [DATA_W-1:0] usp_in,
    input logic [DATA_W-1:0] stat_out,
    input logic [DATA_W-1:0] sp_out,
    input logic [DATA_W-1:0] ksp_out,
    input logic              done
);

    localparam int U_SRC = U_BIT + POP_SHIFT;

    logic go;
    assign go = rfe_go || rfn_go;

    // Input precondition: the two strobes are exclusive
    a_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfe_go && rfn_go));

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (stat_out == '0 && sp_out == '0 && ksp_out == '0 && !done));

    a_r2_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> stat_out[DATA_W-1 -: KEEP_HI] == $past(stat_in[DATA_W-1 -: KEEP_HI]));

    a_r3_p_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !stat_in[R_BIT]) |=> stat_out[P_BIT]);

    a_r4_m_on_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        rfn_go |=> stat_out[M_BIT]);

    a_r5_stack_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (go && stat_in[U_SRC]) |=> (sp_out == $past(usp_in) && ksp_out == $past(sp_in)));

    a_r6_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !stat_in[U_SRC]) |=> (sp_out == $past(sp_in) && $stable(ksp_out)));

    a_r7_done_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);

    a_r7_done_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !done);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(stat_out) && $stable(sp_out) && $stable(ksp_out)));

endmodule

bind xret_status_unit xret_status_sva #(
    .DATA_W    (DATA_W),
    .KEEP_HI   (KEEP_HI),
    .POP_SHIFT (POP_SHIFT),
    .U_BIT     (U_BIT),
    .P_BIT     (P_BIT),
    .R_BIT     (R_BIT),
    .M_BIT     (M_BIT)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .rfe_go   (rfe_go),
    .rfn_go   (rfn_go),
    .stat_in  (stat_in),
    .sp_in    (sp_in),
    .usp_in   (usp_in),
    .stat_out (stat_out),
    .sp_out   (sp_out),
    .ksp_out  (ksp_out),
    .done     (done)
);

// File: tb/xret_status_unit_test.sv
module xret_status_unit_test;

    localparam int W = 32;

    typedef struct packed {
        logic         nmi;
        logic [W-1:0] stat;
        logic [W-1:0] sp;
        logic [W-1:0] usp;
        logic [W-1:0] e_stat;
        logic [W-1:0] e_sp;
        logic [W-1:0] e_ksp;
    } vec_t;

    // nmi, stat_in, sp_in, usp_in, expected stat, sp, ksp
    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h0000_0000, 32'h0000_1000, 32'h0000_2000, 32'h0000_0080, 32'h0000_1000, 32'h0000_0000},
        '{1'b0, 32'hC000_0100, 32'h0000_1100, 32'h0000_2100, 32'hC000_0000, 32'h0000_1100, 32'h0000_0000},
        '{1'b1, 32'h0001_0000, 32'h0000_A000, 32'h0000_B000, 32'h0000_02C0, 32'h0000_B000, 32'h0000_A000},
        '{1'b0, 32'h3000_0100, 32'h0000_3333, 32'h0000_9999, 32'h0000_0000, 32'h0000_3333, 32'h0000_A000},
        '{1'b0, 32'h0FFF_FFFF, 32'h0000_4444, 32'h0000_5555, 32'h0003_FFFF, 32'h0000_5555, 32'h0000_4444},
        '{1'b1, 32'h0002_0100, 32'h0000_6000, 32'h0000_6666, 32'h0000_0280, 32'h0000_6000, 32'h0000_4444},
        '{1'b0, 32'h0008_0100, 32'h0000_7000, 32'h0000_7777, 32'h0000_0200, 32'h0000_7000, 32'h0000_4444},
        '{1'b1, 32'h4000_0400, 32'h0000_8000, 32'h0000_8888, 32'h4000_0281, 32'h0000_8000, 32'h0000_4444}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rfe_go = 1'b0;
    logic         rfn_go = 1'b0;
    logic [W-1:0] stat_in = '0;
    logic [W-1:0] sp_in = '0;
    logic [W-1:0] usp_in = '0;
    logic [W-1:0] stat_out;
    logic [W-1:0] sp_out;
    logic [W-1:0] ksp_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xret_status_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rfe_go   (rfe_go),
        .rfn_go   (rfn_go),
        .stat_in  (stat_in),
        .sp_in    (sp_in),
        .usp_in   (usp_in),
        .stat_out (stat_out),
        .sp_out   (sp_out),
        .ksp_out  (ksp_out),
        .done     (done)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] h_stat, h_sp, h_ksp;

        // R1: reset state
        @(negedge clk);
        chk("R1 stat_out", stat_out, '0);
        chk("R1 sp_out", sp_out, '0);
        chk("R1 ksp_out", ksp_out, '0);
        chk("R1 done", {31'd0, done}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2..R7 on the strobe, R7/R8 on the idle cycle after
        for (int i = 0; i < 8; i++) begin
            stat_in = VECS[i].stat;
            sp_in   = VECS[i].sp;
            usp_in  = VECS[i].usp;
            rfn_go  = VECS[i].nmi;
            rfe_go  = !VECS[i].nmi;
            @(negedge clk);
            rfe_go = 1'b0;
            rfn_go = 1'b0;
            chk($sformatf("R2 R3 R4 stat vec%0d", i), stat_out, VECS[i].e_stat);
            chk($sformatf("R5 R6 sp vec%0d", i), sp_out, VECS[i].e_sp);
            chk($sformatf("R5 R6 ksp vec%0d", i), ksp_out, VECS[i].e_ksp);
            chk($sformatf("R7 done high vec%0d", i), {31'd0, done}, 32'd1);
            h_stat = stat_out;
            h_sp   = sp_out;
            h_ksp  = ksp_out;
            stat_in = ~VECS[i].stat;
            sp_in   = 32'hDEAD_0000 + i;
            usp_in  = 32'hBEEF_0000 + i;
            @(negedge clk);
            chk($sformatf("R7 done low vec%0d", i), {31'd0, done}, '0);
            chk($sformatf("R8 stat hold vec%0d", i), stat_out, h_stat);
            chk($sformatf("R8 sp hold vec%0d", i), sp_out, h_sp);
            chk($sformatf("R8 ksp hold vec%0d", i), ksp_out, h_ksp);
        end

        // Back-to-back returns: done stays high, second result wins (R7, R5)
        stat_in = 32'h0001_0000; sp_in = 32'h0000_0111; usp_in = 32'h0000_0222; rfe_go = 1'b1;
        @(negedge clk);
        chk("R7 first of pair", {31'd0, done}, 32'd1);
        chk("R5 ksp first of pair", ksp_out, 32'h0000_0111);
        stat_in = 32'h0001_0100; sp_in = 32'h0000_0333; usp_in = 32'h0000_0444; rfe_go = 1'b0; rfn_go = 1'b1;
        @(negedge clk);
        rfn_go = 1'b0;
        chk("R7 second of pair", {31'd0, done}, 32'd1);
        chk("R4 R3 stat second of pair", stat_out, 32'h0000_0240);
        chk("R5 sp second of pair", sp_out, 32'h0000_0444);
        chk("R5 ksp second of pair", ksp_out, 32'h0000_0333);

        // Reset in mid-run clears everything again (R1)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 stat_out rerun", stat_out, '0);
        chk("R1 ksp_out rerun", ksp_out, '0);
        chk("R1 done rerun", {31'd0, done}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule